// File: doc/BRIEF.md
# SIMD Lane Divergence Mask Unit

This unit holds the execution mask for an eight-lane SIMD core in which every lane runs the same instruction stream in lockstep. When a conditional branch command arrives with a predicate vector, only the lanes that were already active and whose predicate is true stay enabled for the taken path. An else command then enables only the lanes that were active and whose predicate is false. An endif command restores the mask that was in force before the branch. Nested conditionals are handled by a small stack. Each stack entry holds the enclosing mask and the precomputed else-side mask.

The front end samples `active_mask_o` on every cycle. A path that holds no active lanes raises `skip_o`, which tells the front end to skip that path without issuing from it. An idle-lane counter adds the number of disabled lanes for each issued instruction. It measures the throughput lost to divergence, which in the worst case is seven of eight lanes.

Top module: `simd_mask_unit`

## Requirements
- R1: After reset, `active_mask_o` is 8'hFF, `depth_o` is 0, `idle_cnt_o` is 0, and `overflow_o`, `underflow_o` and `skip_o` are all low.
- R2: A branch command at a depth below 4 sets the mask to the old mask AND `pred_i` from the next cycle onward, and increments `depth_o` by one.
- R3: An else command at a nonzero depth sets the mask to the enclosing mask AND NOT the predicate of the innermost open branch. Depth does not change.
- R4: An endif command at a nonzero depth restores the enclosing mask of the innermost open branch and decrements `depth_o` by one.
- R5: Branches nest up to 4 levels, and each endif restores the mask of its own level.
- R6: A branch command at depth 4 raises `overflow_o` for exactly the next cycle. Mask and depth stay unchanged.
- R7: An else or endif command at depth 0 raises `underflow_o` for exactly the next cycle. Mask and depth stay unchanged.
- R8: `skip_o` is high exactly when depth is nonzero and the mask is all zeros. An `issue_i` pulse in that state does not change `idle_cnt_o`.
- R9: On each cycle with `issue_i` high and `skip_o` low, `idle_cnt_o` increases by 8 minus the number of set bits in the current mask. With a single active lane it therefore increases by 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| branch_i | input | 1 | Branch command; opens a conditional |
| pred_i | input | 8 | Per-lane predicate, sampled together with branch_i |
| else_i | input | 1 | Else command; switches to the false lanes |
| endif_i | input | 1 | Endif command; reconverges |
| issue_i | input | 1 | An instruction issues this cycle |
| active_mask_o | output | 8 | Lanes enabled for the current instruction |
| skip_o | output | 1 | Current path has no active lanes |
| depth_o | output | 3 | Number of open conditionals |
| overflow_o | output | 1 | Branch was rejected because the stack was full |
| underflow_o | output | 1 | Else or endif was rejected because the stack was empty |
| idle_cnt_o | output | 32 | Accumulated idle lane-cycles |

## Verification
The assertions assume that at most one of `branch_i`, `else_i` and `endif_i` is high in any cycle; the checker states this as an input assumption. The random stimulus selects one command, or none, per cycle, so the commands are always mutually exclusive. Overflow and underflow are legal cases. The stimulus exercises them on purpose through directed deep nesting and an endif on an empty stack, and the random mix also reaches them by chance.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_BRANCH = 2'd1,
    OP_ELSE   = 2'd2,
    OP_ENDIF  = 2'd3
  } mask_op_e;
endpackage

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] enc_i,
  input  logic [LANES-1:0] els_i,
  output logic [LANES-1:0] top_enc_o,
  output logic [LANES-1:0] top_els_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [PW-1:0]    ptr_o
);
  logic [LANES-1:0] enc_q [DEPTH];
  logic [LANES-1:0] els_q [DEPTH];
  logic [PW-1:0]    ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        enc_q[i] <= '1;
        els_q[i] <= '0;
      end
    end else if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (PW'(i) == ptr_q) begin
          enc_q[i] <= enc_i;
          els_q[i] <= els_i;
        end
      end
      ptr_q <= ptr_q + 1'b1;
    end else if (pop_i) begin
      ptr_q <= ptr_q - 1'b1;
    end
  end

  always_comb begin
    top_enc_o = '1;
    top_els_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (PW'(i + 1) == ptr_q) begin
        top_enc_o = enc_q[i];
        top_els_o = els_q[i];
      end
    end
  end

  assign full_o  = (ptr_q == PW'(DEPTH));
  assign empty_o = (ptr_q == '0);
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/mask_cmd_ctrl.sv
module mask_cmd_ctrl
  import simd_mask_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             branch_i,
  input  logic             else_i,
  input  logic             endif_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [LANES-1:0] top_enc_i,
  input  logic [LANES-1:0] top_els_i,
  input  logic             full_i,
  input  logic             empty_i,
  output logic             push_o,
  output logic             pop_o,
  output logic [LANES-1:0] push_els_o,
  output logic [LANES-1:0] mask_d_o,
  output logic             ovf_o,
  output logic             unf_o
);
  mask_op_e op;

  // fixed priority; inputs are expected one-hot
  always_comb begin
    if (branch_i)     op = OP_BRANCH;
    else if (else_i)  op = OP_ELSE;
    else if (endif_i) op = OP_ENDIF;
    else              op = OP_NONE;
  end

  assign push_els_o = mask_i & ~pred_i;

  always_comb begin
    push_o   = 1'b0;
    pop_o    = 1'b0;
    ovf_o    = 1'b0;
    unf_o    = 1'b0;
    mask_d_o = mask_i;
    unique case (op)
      OP_BRANCH: begin
        if (full_i) ovf_o = 1'b1;
        else begin
          push_o   = 1'b1;
          mask_d_o = mask_i & pred_i;
        end
      end
      OP_ELSE: begin
        if (empty_i) unf_o = 1'b1;
        else         mask_d_o = top_els_i;
      end
      OP_ENDIF: begin
        if (empty_i) unf_o = 1'b1;
        else begin
          pop_o    = 1'b1;
          mask_d_o = top_enc_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idle_lane_counter.sv
module idle_lane_counter #(
  parameter int LANES = 8,
  parameter int CNT_W = 32,
  localparam int PCW = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_en_i,
  input  logic [LANES-1:0] mask_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PCW-1:0] ones;
  logic [PCW-1:0] idle;

  always_comb begin
    ones = '0;
    for (int i = 0; i < LANES; i++) ones = ones + PCW'(mask_i[i]);
  end

  assign idle = PCW'(LANES) - ones;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= '0;
    else if (count_en_i) cnt_o <= cnt_o + CNT_W'(idle);
  end
endmodule

// File: rtl/simd_mask_unit.sv
module simd_mask_unit #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 32,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             branch_i,
  input  logic [LANES-1:0] pred_i,
  input  logic             else_i,
  input  logic             endif_i,
  input  logic             issue_i,
  output logic [LANES-1:0] active_mask_o,
  output logic             skip_o,
  output logic [PW-1:0]    depth_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic [CNT_W-1:0] idle_cnt_o
);
  logic [LANES-1:0] mask_q, mask_d, top_enc, top_els, push_els;
  logic push, pop, full, empty, ovf, unf;

  mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop),
    .enc_i(mask_q), .els_i(push_els),
    .top_enc_o(top_enc), .top_els_o(top_els),
    .full_o(full), .empty_o(empty), .ptr_o(depth_o)
  );

  mask_cmd_ctrl #(.LANES(LANES)) u_ctrl (
    .branch_i, .else_i, .endif_i, .pred_i,
    .mask_i(mask_q), .top_enc_i(top_enc), .top_els_i(top_els),
    .full_i(full), .empty_i(empty),
    .push_o(push), .pop_o(pop), .push_els_o(push_els),
    .mask_d_o(mask_d), .ovf_o(ovf), .unf_o(unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '1;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      mask_q      <= mask_d;
      overflow_o  <= ovf;
      underflow_o <= unf;
    end
  end

  assign skip_o        = !empty && (mask_q == '0);
  assign active_mask_o = mask_q;

  idle_lane_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .count_en_i(issue_i && !skip_o),
    .mask_i(mask_q),
    .cnt_o(idle_cnt_o)
  );
endmodule

// File: rtl/simd_mask_unit_chk.sv
module simd_mask_unit_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 32,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             branch_i,
  input logic [LANES-1:0] pred_i,
  input logic             else_i,
  input logic             endif_i,
  input logic             issue_i,
  input logic [LANES-1:0] active_mask_o,
  input logic             skip_o,
  input logic [PW-1:0]    depth_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic [CNT_W-1:0] idle_cnt_o
);
  // input assumption: commands mutually exclusive
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({branch_i, else_i, endif_i}));

  // R1
  top_level_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o == '0 |-> active_mask_o == '1);

  // R2
  branch_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i && depth_o != PW'(DEPTH) |=>
      active_mask_o == ($past(active_mask_o) & $past(pred_i)) && depth_o == $past(depth_o) + 1'b1);

  // R4
  endif_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    endif_i && depth_o != '0 |=> depth_o == $past(depth_o) - 1'b1);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i && depth_o == PW'(DEPTH) |=> overflow_o && $stable(depth_o) && $stable(active_mask_o));

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (else_i || endif_i) && depth_o == '0 |=> underflow_o && $stable(active_mask_o));

  // R8
  skip_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> $stable(idle_cnt_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(idle_cnt_o));
endmodule

bind simd_mask_unit simd_mask_unit_chk #(.LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .branch_i(branch_i), .pred_i(pred_i),
  .else_i(else_i), .endif_i(endif_i), .issue_i(issue_i),
  .active_mask_o(active_mask_o), .skip_o(skip_o), .depth_o(depth_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .idle_cnt_o(idle_cnt_o)
);

// File: tb/simd_mask_unit_bench.sv
module simd_mask_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        branch_i = 1'b0, else_i = 1'b0, endif_i = 1'b0, issue_i = 1'b0;
  logic [7:0]  pred_i = '0;
  logic [7:0]  active_mask_o;
  logic        skip_o, overflow_o, underflow_o;
  logic [2:0]  depth_o;
  logic [31:0] idle_cnt_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  m_enc [4];
  logic [7:0]  m_els [4];
  int          m_dep;
  logic [7:0]  m_mask;
  logic [31:0] m_cnt;
  bit          m_ovf, m_unf;
  string       tag;

  always #4 clk_i = ~clk_i;

  simd_mask_unit u_simd_mask_unit (.*);

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic bit m_skip();
    return m_dep != 0 && m_mask == 8'h00;
  endfunction

  task automatic check_all(string r);
    chk({r, " mask"}, 64'(active_mask_o), 64'(m_mask));
    chk({r, " depth"}, 64'(depth_o), 64'(m_dep));
    chk({r, " cnt"}, 64'(idle_cnt_o), 64'(m_cnt));
    chk({r, " ovf"}, 64'(overflow_o), 64'(m_ovf));
    chk({r, " unf"}, 64'(underflow_o), 64'(m_unf));
    chk({r, " skip"}, 64'(skip_o), 64'(m_skip()));
  endtask

  // drive at negedge, update model to post-edge state, check next negedge
  task automatic step(int op, logic [7:0] p, bit iss);
    branch_i = (op == 1); else_i = (op == 2); endif_i = (op == 3);
    pred_i = p; issue_i = iss;
    if (iss && !m_skip()) m_cnt += 32'(8 - $countones(m_mask));
    m_ovf = 0; m_unf = 0;
    tag = iss ? "R9" : "R1";
    case (op)
      1: if (m_dep == 4) begin m_ovf = 1; tag = "R6"; end
         else begin
           m_enc[m_dep] = m_mask; m_els[m_dep] = m_mask & ~p;
           m_mask = m_mask & p; m_dep++; tag = "R2";
         end
      2: if (m_dep == 0) begin m_unf = 1; tag = "R7"; end
         else begin m_mask = m_els[m_dep-1]; tag = "R3"; end
      3: if (m_dep == 0) begin m_unf = 1; tag = "R7"; end
         else begin m_dep--; m_mask = m_enc[m_dep]; tag = "R4"; end
      default: ;
    endcase
    @(negedge clk_i);
    branch_i = 0; else_i = 0; endif_i = 0; issue_i = 0;
    check_all(tag);
  endtask

  initial begin
    m_dep = 0; m_mask = 8'hFF; m_cnt = 0; m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // R9 worst case: one lane active
    step(1, 8'h04, 0);
    step(0, 8'h00, 1);
    chk("R9 single lane idle", 64'(idle_cnt_o), 64'd7);
    step(2, 8'h00, 1);
    chk("R3 else mask", 64'(active_mask_o), 64'hFB);
    step(3, 8'h00, 1);
    chk("R4 restore", 64'(active_mask_o), 64'hFF);

    // R5 nesting to full depth then R6 overflow
    step(1, 8'hF0, 1);
    step(1, 8'h3C, 1);
    step(1, 8'hAA, 1);
    step(1, 8'h7F, 1);
    chk("R5 depth 4", 64'(depth_o), 64'd4);
    chk("R5 nested mask", 64'(active_mask_o), 64'h20);
    step(1, 8'hFF, 0);
    chk("R6 overflow", 64'(overflow_o), 64'd1);
    step(0, 8'h00, 0);
    chk("R6 pulse clears", 64'(overflow_o), 64'd0);
    step(3, 8'h00, 0);
    chk("R5 level 3 mask", 64'(active_mask_o), 64'h20);
    step(3, 8'h00, 0);
    step(3, 8'h00, 0);
    chk("R5 level 1 mask", 64'(active_mask_o), 64'hF0);
    step(3, 8'h00, 0);

    // R7 underflow on empty stack
    step(3, 8'h00, 0);
    chk("R7 underflow", 64'(underflow_o), 64'd1);
    step(2, 8'h00, 0);
    chk("R7 underflow else", 64'(underflow_o), 64'd1);

    // R8 all-false predicate: empty then-path
    step(1, 8'h00, 0);
    chk("R8 skip", 64'(skip_o), 64'd1);
    begin
      logic [31:0] c0;
      c0 = idle_cnt_o;
      step(0, 8'h00, 1);
      chk("R8 issue ignored", 64'(idle_cnt_o), 64'(c0));
    end
    step(2, 8'h00, 0);
    chk("R8 else full", 64'(skip_o), 64'd0);
    step(3, 8'h00, 0);

    // random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r < 3 ? 1 : r < 5 ? 2 : r < 7 ? 3 : 0,
           8'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule